// File: doc/BRIEF.md
# Streaming Page Load/Read Data Register for a Test Port

This block sits behind a test access port and lets a debugger move one whole memory page, 128 bytes, through a single data register scan. The scan behaves like a very long register, but only an 8-bit shift register is built. A small sequencer turns the serial stream into byte transfers with a page buffer while the TAP stays in its shift state.

Two instruction codes select the block. With the load code, bits arriving on TDI are packed into bytes, least significant bit first. Each finished byte is written to the next page-buffer address. A full page takes 1024 shift cycles. With the read code, bytes are fetched from the page buffer and sent out on TDO, least significant bit first. Eight filler bits come first while the first byte is fetched, so a full page takes 1032 shift cycles. All transfers happen inside the shift state. Capture and update cause no buffer access.

The page buffer is a synchronous byte port. The address is sampled on a rising TCK edge, and the read data appears after that edge. A write takes place on the rising edge at which the write enable is high.

Top module: `jtag_page_stream`

## Requirements
- R1: Only instruction code 0x6 (load) and 0x7 (read) activate the block. With any other code, shifting writes nothing and TDO stays 0.
- R2: In load mode, TDI bits are assembled least significant bit first. After every eighth shift edge, `buf_we` is high for exactly the following cycle, with the assembled byte on `buf_wdata` and its address on `buf_addr`.
- R3: Load addresses start at 0 on every entry into Shift-DR and rise by one per byte. After address 127 they wrap to 0, so 1024 bits fill one page.
- R4: A partial byte left when Shift-DR ends is discarded. No write happens outside the cycle that follows a completed byte, so leaving the shift state, capture and update perform no transfer.
- R5: In read mode, the first 8 TDO bits are 0. After them come the bytes at addresses 0, 1, 2 and so on, each least significant bit first. A whole page plus filler takes 1032 bits.
- R6: The read address wraps after 128 bytes, so the byte after address 127 is the byte at address 0.
- R7: In read mode, TDI is ignored: different TDI streams give the same TDO stream, and no write occurs.
- R8: While reset is held, TDO, `buf_we` and `buf_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current instruction register value |
| shift_dr | input | 1 | High while the TAP is in Shift-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| buf_addr | output | 7 | Page buffer byte address |
| buf_wdata | output | 8 | Byte to write to the page buffer |
| buf_we | output | 1 | Page buffer write enable, one cycle per stored byte |
| buf_rdata | input | 8 | Byte read from the page buffer, valid after the edge that sampled the address |

## Verification
The bound checker watches every cycle. It checks that the address clears outside an active shift and steps with each byte, and that every write strobe follows a completed byte one cycle later. It checks that a fetched byte appears on TDO right after the fetch, that zeros rather than TDI enter the register in read mode, and that an unknown code leaves TDO at 0. Some behaviours only the bench scenarios can show:
- the data actually carried end to end, with LSB-first packing confirmed by reading back what was loaded;
- the 8-bit filler;
- address wrap on a 130-byte load and a 130-byte read;
- a discarded partial byte that leaves the buffer untouched;
- identical TDO streams under different TDI patterns.

// File: rtl/jps_pkg.sv
package jps_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_READ = 2'd2
  } jps_mode_e;

  // Next byte address inside a page of 'limit' bytes, wrapping to zero.
  function automatic int unsigned wrap_inc(int unsigned a, int unsigned limit);
    return (a + 1 >= limit) ? 0 : a + 1;
  endfunction

  // Map an instruction value onto the block's operating mode.
  function automatic jps_mode_e decode_mode(int unsigned ir, int unsigned load_code,
                                            int unsigned read_code);
    if (ir == load_code) return MODE_LOAD;
    if (ir == read_code) return MODE_READ;
    return MODE_IDLE;
  endfunction

endpackage

// File: rtl/jps_bit_counter.sv
module jps_bit_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic byte_done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign byte_done = step && (cnt == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/jps_addr_seq.sv
module jps_addr_seq
  import jps_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (clear)   addr <= '0;
    else if (advance) addr <= ADDR_W'(wrap_inc(32'(addr), PAGE_BYTES));
  end
endmodule

// File: rtl/jps_shifter.sv
module jps_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clear)    q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {ser_in, q[DATA_W-1:1]};
  end
endmodule

// File: rtl/jtag_page_stream.sv
module jtag_page_stream
  import jps_pkg::*;
#(
  parameter int unsigned LOAD_CODE  = 6,
  parameter int unsigned READ_CODE  = 7,
  parameter int          IR_W       = 4,
  parameter int          DATA_W     = 8,
  parameter int          PAGE_BYTES = 128,
  localparam int         ADDR_W     = $clog2(PAGE_BYTES)
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              shift_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              buf_we,
  input  logic [DATA_W-1:0] buf_rdata
);
  // Mode decode and named internal events
  jps_mode_e   mode;
  logic        load_sel, read_sel, active, read_mode, load_mode;
  logic        byte_done, store_evt, fetch_evt, sr_msb;
  logic [ADDR_W-1:0] addr_now;
  logic [DATA_W-1:0] sr_q, assembled;

  assign mode      = decode_mode(32'(ir_code), LOAD_CODE, READ_CODE);
  assign load_sel  = (mode == MODE_LOAD);
  assign read_sel  = (mode == MODE_READ);
  assign active    = shift_dr && (load_sel || read_sel);
  assign load_mode = active && load_sel;
  assign read_mode = active && read_sel;
  assign store_evt = load_mode && byte_done;
  assign fetch_evt = read_mode && byte_done;

  jps_bit_counter #(.DATA_W(DATA_W)) bit_cnt_i (
    .clk(tck), .rst_n(rst_n), .clear(!active), .step(active), .byte_done(byte_done)
  );

  jps_addr_seq #(.PAGE_BYTES(PAGE_BYTES)) addr_i (
    .clk(tck), .rst_n(rst_n), .clear(!active), .advance(active && byte_done),
    .addr(addr_now)
  );

  // Zeros enter in read mode so TDI has no effect there.
  jps_shifter #(.DATA_W(DATA_W)) sr_i (
    .clk(tck), .rst_n(rst_n), .clear(!active), .shift_en(active),
    .ser_in(load_sel ? tdi : 1'b0), .load_en(fetch_evt), .load_val(buf_rdata),
    .q(sr_q)
  );

  assign assembled = {tdi, sr_q[DATA_W-1:1]};
  assign sr_msb    = sr_q[DATA_W-1];
  assign tdo       = sr_q[0];

  // Write stage: one registered strobe per completed byte
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] waddr_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
    end else begin
      we_q <= store_evt;
      if (store_evt) begin
        wdata_q <= assembled;
        waddr_q <= addr_now;
      end
    end
  end

  assign buf_we    = we_q;
  assign buf_wdata = wdata_q;
  assign buf_addr  = we_q ? waddr_q : addr_now;
endmodule

// File: rtl/jps_checker.sv
module jps_checker
  import jps_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_dr,
  input logic              load_sel,
  input logic              read_sel,
  input logic              active,
  input logic              read_mode,
  input logic              byte_done,
  input logic              store_evt,
  input logic              fetch_evt,
  input logic [ADDR_W-1:0] addr_now,
  input logic              sr_msb,
  input logic              tdo,
  input logic              buf_we,
  input logic [DATA_W-1:0] buf_rdata
);
  // R3
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (addr_now == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_done) |=> (addr_now == ADDR_W'(wrap_inc(32'($past(addr_now)), PAGE_BYTES))));

  // R2
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> buf_we);

  // R4
  we_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(store_evt));

  // R5
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (tdo == $past(buf_rdata[0])));

  // R7
  tdi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode && !byte_done) |=> !sr_msb);

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && !load_sel && !read_sel) |=> !tdo);
endmodule

bind jtag_page_stream jps_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) chk_i (
  .clk(tck), .rst_n(rst_n), .shift_dr(shift_dr), .load_sel(load_sel),
  .read_sel(read_sel), .active(active), .read_mode(read_mode),
  .byte_done(byte_done), .store_evt(store_evt), .fetch_evt(fetch_evt),
  .addr_now(addr_now), .sr_msb(sr_msb), .tdo(tdo), .buf_we(buf_we),
  .buf_rdata(buf_rdata)
);

// File: tb/jtag_page_stream_tb_top.sv
module jtag_page_stream_tb_top;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ir_code = 4'h0;
  logic       shift_dr = 1'b0;
  logic       tdi = 1'b0;
  logic       tdo;
  logic [6:0] buf_addr;
  logic [7:0] buf_wdata;
  logic       buf_we;
  logic [7:0] buf_rdata = 8'h00;

  logic       pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] mem [128];
  logic [7:0] page_ref [128];

  typedef struct packed {logic [6:0] addr; logic [7:0] data;} wr_t;
  wr_t wq[$];

  always #2 tck = ~tck;

  jtag_page_stream dut_i (
    .tck(tck), .rst_n(rst_n), .ir_code(ir_code), .shift_dr(shift_dr), .tdi(tdi),
    .tdo(tdo), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
    .buf_rdata(buf_rdata)
  );

  // Synchronous page buffer model with a bench-only preload path
  always @(posedge tck) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (buf_we) mem[buf_addr] <= buf_wdata;
    buf_rdata <= mem[buf_addr];
  end

  task automatic check(string req, logic ok, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  // Monitor: pops expected writes as the design issues them (R2, R3, R4)
  always @(negedge tck) begin
    if (rst_n && buf_we) begin
      if (wq.size() == 0) begin
        check("R4", 1'b0, $sformatf("unexpected write actual addr %0d data %02h expected none",
                                    buf_addr, buf_wdata));
      end else begin
        wr_t e;
        e = wq.pop_front();
        check("R2", buf_wdata == e.data,
              $sformatf("write data actual %02h expected %02h", buf_wdata, e.data));
        check("R3", buf_addr == e.addr,
              $sformatf("write addr actual %0d expected %0d", buf_addr, e.addr));
      end
    end
  end

  function automatic logic [7:0] pat(int k, int seed);
    return 8'((k * 37 + seed * 11) ^ (k >> 2) ^ (seed << 4));
  endfunction

  task automatic clk_bit(input logic b, output logic o);
    @(negedge tck);
    o = tdo;
    tdi = b;
    shift_dr = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      shift_dr = 1'b0;
      tdi = 1'b0;
    end
  endtask

  // Driver: shifts bytes in load mode and pushes the expected writes
  task automatic load_bytes(int n, int seed, int extra_bits, string req);
    logic o;
    ir_code = 4'h6;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = pat(k, seed);
      page_ref[k % 128] = d;
      wq.push_back('{addr: 7'(k % 128), data: d});
      for (int j = 0; j < 8; j++) clk_bit(d[j], o);
    end
    for (int e = 0; e < extra_bits; e++) clk_bit(1'b1, o);
    idle(4);
    check(req, wq.size() == 0,
          $sformatf("pending writes actual %0d expected 0", wq.size()));
  endtask

  // tdi_mode: 0 all zero, 1 all one, 2 alternating
  task automatic read_stream(int nbytes, int tdi_mode, string req);
    logic o;
    logic [7:0] got;
    ir_code = 4'h7;
    got = '0;
    for (int j = 0; j < 8; j++) begin
      clk_bit(tdi_mode == 0 ? 1'b0 : (tdi_mode == 1 ? 1'b1 : 1'(j)), o);
      got[j] = o;
    end
    check("R5", got == 8'h00, $sformatf("filler actual %02h expected 00", got));
    for (int k = 0; k < nbytes; k++) begin
      for (int j = 0; j < 8; j++) begin
        clk_bit(tdi_mode == 0 ? 1'b0 : (tdi_mode == 1 ? 1'b1 : 1'(j + k)), o);
        got[j] = o;
      end
      check(k >= 128 ? "R6" : req, got == page_ref[k % 128],
            $sformatf("read byte %0d actual %02h expected %02h", k, got, page_ref[k % 128]));
    end
    idle(3);
  endtask

  task automatic preload(int seed);
    for (int a = 0; a < 128; a++) begin
      @(negedge tck);
      pre_we = 1'b1;
      pre_addr = 7'(a);
      pre_data = pat(a, seed);
      page_ref[a] = pat(a, seed);
    end
    @(negedge tck);
    pre_we = 1'b0;
  endtask

  initial begin
    logic o;
    logic [23:0] seen;
    for (int a = 0; a < 128; a++) begin
      mem[a] = 8'h00;
      page_ref[a] = 8'h00;
    end
    repeat (3) @(negedge tck);
    // R8: reset state
    check("R8", tdo == 1'b0, $sformatf("tdo actual %b expected 0", tdo));
    check("R8", buf_we == 1'b0, $sformatf("buf_we actual %b expected 0", buf_we));
    check("R8", buf_addr == 7'd0, $sformatf("buf_addr actual %0d expected 0", buf_addr));
    @(negedge tck);
    rst_n = 1'b1;
    idle(2);

    // R1: an unrelated instruction does nothing
    ir_code = 4'h5;
    seen = '0;
    for (int j = 0; j < 24; j++) begin
      clk_bit(1'(j), o);
      seen[j] = o;
    end
    idle(4);
    check("R1", seen == 24'h0, $sformatf("tdo stream actual %06h expected 000000", seen));
    check("R1", wq.size() == 0, "write queue not empty");

    // R2 R3: full page plus two bytes, address wraps
    load_bytes(130, 3, 0, "R3");
    // R5 R6: read back the page and one wrapped byte, LSB order end to end
    read_stream(129, 0, "R5");
    // R7: TDI held high during read must not change the data
    read_stream(6, 1, "R7");
    // R4: partial byte discarded, address 2 untouched
    load_bytes(2, 11, 5, "R4");
    read_stream(4, 2, "R4");
    // R5 R6 R7: fresh preloaded page, alternating TDI, wrap
    preload(5);
    read_stream(130, 2, "R7");

    idle(4);
    summary();
    $finish;
  end
endmodule